// File: doc/BRIEF.md
# Prescaled Match/Capture Timer

This block is a 32-bit timer/counter meant to sit on a simple register bus inside a larger chip. In timer mode a free-running prescale counter divides the clock, and the main count advances once for every full prescale period. In counter mode the main count instead advances on each rising edge of a synchronized external event input, and the prescaler is bypassed.

Four match channels compare their own compare value against the main count. When a counting event occurs while the count equals a channel's value, that channel can do any mix of three things: raise an interrupt flag, clear the count, or halt counting. Each channel also drives an external pin, which can be driven low, driven high, inverted or left as it is. Two capture channels watch their input pins through a two-stage synchronizer. On a chosen edge they take a snapshot of the count and can optionally raise a flag. A single interrupt line is the OR of all pending flags.

Software uses a word-addressed write/read port to set the prescale value, compare values, match actions, capture edges, pin actions and the run, hold and mode bits.

Top module: `match_capture_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `extOut` is zero. Word addresses: 0 control (bit0 run, bit1 hold-at-zero, bit2 external-count mode), 1 prescale, 2 main count (read only), 3 prescale count (read only), 4..7 compare values of channels 0..3, 8 match actions, 9 capture setup, 10 pin control, 11 flags, 12..13 capture snapshots 0..1 (read only).
- R2: In timer mode with run set, the prescale count steps once per clock and returns to zero after it equals the prescale value. The main count advances on exactly that clock, so it advances once every prescale+1 enabled clocks.
- R3: While the hold bit is set, the main count and the prescale count are both zero and do not move.
- R4: Match action bits for channel k sit at bit 3k (flag), bit 3k+1 (clear) and bit 3k+2 (halt). With clear enabled, a counting event that finds the count equal to the compare value loads zero instead of count+1.
- R5: With halt enabled, that counting event leaves the count at the compare value and clears the run bit. A software write to the control register in the same clock takes priority.
- R6: A match sets flag bit k only when its flag bit in the action register is set. `irq` is high whenever any flag is set.
- R7: Writing 1 to a bit of the flag register (bits 0..3 match, bits 4..5 capture) clears that bit, and writing 0 leaves it. A new event in the same clock takes priority over the clear.
- R8: The pin control register holds the pin levels in bits 3..0 and the action code of channel k in bits 5+2k..4+2k: 00 keep, 01 drive low, 10 drive high, 11 invert. The code is applied on every match event of that channel. Writing the register loads pin levels directly.
- R9: The capture setup bits for channel k are bit 3k (rising edge), bit 3k+1 (falling edge) and bit 3k+2 (flag). On an enabled edge of the synchronized input, the snapshot register loads the main count on the third clock edge after the pin changes. Disabled edges load nothing.
- R10: A capture event sets flag bit 4+k only when its flag-enable bit is set.
- R11: In external-count mode with run set, the main count advances once per rising edge of `evtIn`, and the prescale value has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 4 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| evtIn | input | 1 | External count event (asynchronous) |
| capIn | input | 2 | Capture inputs (asynchronous) |
| irq | output | 1 | Interrupt request, OR of pending flags |
| extOut | output | 4 | Match-driven external pins |

## Verification
A wrong prescale count changes the spacing of main-count steps. It shows up in the count readback after one prescale period. A stale comparison or a missed match event is visible within one counting event: the count fails to wrap or halt, the run bit does not clear, or a pin does not switch on `extOut`. A fault in the synchronizer or in edge selection moves or suppresses the snapshot value, readable three clocks after the capture pin changes. Flag errors appear at `irq` on the clock after the event.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef struct packed {
    logic runEn;
    logic holdZero;
    logic countExt;
    logic matchClear;
    logic matchHalt;
  } tmrStrobe_t;

  localparam int A_CTRL   = 0;
  localparam int A_PRE    = 1;
  localparam int A_TC     = 2;
  localparam int A_PC     = 3;
  localparam int A_MATCH0 = 4;
  localparam int A_MCTL   = 8;
  localparam int A_CCTL   = 9;
  localparam int A_EXT    = 10;
  localparam int A_FLAG   = 11;
  localparam int A_CAP0   = 12;

endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int W  = 32,
  parameter int NM = 4,
  parameter int NC = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tmrStrobe_t             strb,
  input  logic [W-1:0]           prescale,
  input  logic [NM-1:0][W-1:0]   matchVal,
  input  logic [NC-1:0]          capLoad,
  input  logic                   evtIn,
  input  logic [NC-1:0]          capIn,
  output logic                   tick,
  output logic [NM-1:0]          matchEq,
  output logic [W-1:0]           tcount,
  output logic [W-1:0]           pcount,
  output logic [NC-1:0]          capRise,
  output logic [NC-1:0]          capFall,
  output logic [NC-1:0][W-1:0]   capVal
);

  localparam int SW = NC + 1;

  logic [SW-1:0] syncA, syncB, syncPrev, riseAll;
  logic          evtRise;
  logic          prescaleWrap;

  // two flops against metastability, a third remembers the last level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= {evtIn, capIn};
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign riseAll = syncB & ~syncPrev;
  assign evtRise = riseAll[NC];
  assign capRise = riseAll[NC-1:0];
  assign capFall = ~syncB[NC-1:0] & syncPrev[NC-1:0];

  assign prescaleWrap = (pcount == prescale);
  assign tick = strb.runEn && !strb.holdZero &&
                (strb.countExt ? evtRise : prescaleWrap);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcount <= '0;
    end else if (strb.holdZero) begin
      pcount <= '0;
    end else if (strb.runEn && !strb.countExt) begin
      pcount <= prescaleWrap ? '0 : pcount + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tcount <= '0;
    end else if (strb.holdZero) begin
      tcount <= '0;
    end else if (tick) begin
      if (strb.matchClear)     tcount <= '0;
      else if (!strb.matchHalt) tcount <= tcount + W'(1);
    end
  end

  for (genvar g = 0; g < NM; g++) begin : gMatch
    assign matchEq[g] = (tcount == matchVal[g]);
  end

  for (genvar c = 0; c < NC; c++) begin : gCap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           capVal[c] <= '0;
      else if (capLoad[c]) capVal[c] <= tcount;
    end

    // R9
    cap_snapshot_chk: assert property (@(posedge clk) disable iff (!rstN)
      capLoad[c] |=> capVal[c] == $past(tcount));
  end

  // R3
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.holdZero |=> (tcount == '0 && pcount == '0));

  // R2
  prescale_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.runEn && !strb.holdZero && !strb.countExt && pcount != prescale)
      |=> tcount == $past(tcount));

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int W      = 32,
  parameter int NM     = 4,
  parameter int NC     = 2,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWe,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [W-1:0]           busWdata,
  output logic [W-1:0]           busRdata,
  input  logic                   tick,
  input  logic [NM-1:0]          matchEq,
  input  logic [W-1:0]           tcount,
  input  logic [W-1:0]           pcount,
  input  logic [NC-1:0]          capRise,
  input  logic [NC-1:0]          capFall,
  input  logic [NC-1:0][W-1:0]   capVal,
  output tmrStrobe_t             strb,
  output logic [W-1:0]           prescale,
  output logic [NM-1:0][W-1:0]   matchVal,
  output logic [NC-1:0]          capLoad,
  output logic                   irq,
  output logic [NM-1:0]          extOut
);

  localparam int MCTL_W = 3 * NM;
  localparam int CCTL_W = 3 * NC;
  localparam int EXT_W  = 3 * NM;
  localparam int FLAG_W = NM + NC;

  logic                runBit, holdBit, modeBit;
  logic [MCTL_W-1:0]   mctl;
  logic [CCTL_W-1:0]   cctl;
  logic [NM-1:0]       extState;
  logic [2*NM-1:0]     extCode;
  logic [FLAG_W-1:0]   flags;

  logic [NM-1:0] matchEvt, intMaskM, rstMaskM, haltMaskM;
  logic [NC-1:0] intMaskC;
  logic          clearHit, haltHit;
  logic          wrCtrl, wrPre, wrMctl, wrCctl, wrExt, wrFlag;
  logic [FLAG_W-1:0] setBits, clrBits;

  assign wrCtrl = busWe && busAddr == ADDR_W'(A_CTRL);
  assign wrPre  = busWe && busAddr == ADDR_W'(A_PRE);
  assign wrMctl = busWe && busAddr == ADDR_W'(A_MCTL);
  assign wrCctl = busWe && busAddr == ADDR_W'(A_CCTL);
  assign wrExt  = busWe && busAddr == ADDR_W'(A_EXT);
  assign wrFlag = busWe && busAddr == ADDR_W'(A_FLAG);

  for (genvar k = 0; k < NM; k++) begin : gMask
    assign intMaskM[k]  = mctl[3*k];
    assign rstMaskM[k]  = mctl[3*k+1];
    assign haltMaskM[k] = mctl[3*k+2];
  end

  for (genvar c = 0; c < NC; c++) begin : gCapSel
    assign capLoad[c]  = (capRise[c] & cctl[3*c]) | (capFall[c] & cctl[3*c+1]);
    assign intMaskC[c] = cctl[3*c+2];
  end

  assign matchEvt = {NM{tick}} & matchEq;
  assign clearHit = |(matchEvt & rstMaskM);
  assign haltHit  = |(matchEvt & haltMaskM);
  assign setBits  = {capLoad & intMaskC, matchEvt & intMaskM};
  assign clrBits  = wrFlag ? busWdata[FLAG_W-1:0] : '0;

  assign strb.runEn      = runBit;
  assign strb.holdZero   = holdBit;
  assign strb.countExt   = modeBit;
  assign strb.matchClear = clearHit;
  assign strb.matchHalt  = haltHit;

  assign irq    = |flags;
  assign extOut = extState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit   <= 1'b0;
      holdBit  <= 1'b0;
      modeBit  <= 1'b0;
      prescale <= '0;
      matchVal <= '0;
      mctl     <= '0;
      cctl     <= '0;
      flags    <= '0;
    end else begin
      if (wrCtrl)       {modeBit, holdBit, runBit} <= busWdata[2:0];
      else if (haltHit) runBit <= 1'b0;
      if (wrPre)  prescale <= busWdata;
      if (wrMctl) mctl     <= busWdata[MCTL_W-1:0];
      if (wrCctl) cctl     <= busWdata[CCTL_W-1:0];
      for (int k = 0; k < NM; k++) begin
        if (busWe && busAddr == ADDR_W'(A_MATCH0 + k)) matchVal[k] <= busWdata;
      end
      flags <= (flags & ~clrBits) | setBits;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extState <= '0;
      extCode  <= '0;
    end else if (wrExt) begin
      extState <= busWdata[NM-1:0];
      extCode  <= busWdata[EXT_W-1:NM];
    end else begin
      for (int k = 0; k < NM; k++) begin
        if (matchEvt[k]) begin
          case (extCode[2*k +: 2])
            2'b01:   extState[k] <= 1'b0;
            2'b10:   extState[k] <= 1'b1;
            2'b11:   extState[k] <= ~extState[k];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(A_CTRL): busRdata[2:0] = {modeBit, holdBit, runBit};
      ADDR_W'(A_PRE):  busRdata = prescale;
      ADDR_W'(A_TC):   busRdata = tcount;
      ADDR_W'(A_PC):   busRdata = pcount;
      ADDR_W'(A_MCTL): busRdata[MCTL_W-1:0] = mctl;
      ADDR_W'(A_CCTL): busRdata[CCTL_W-1:0] = cctl;
      ADDR_W'(A_EXT):  busRdata[EXT_W-1:0] = {extCode, extState};
      ADDR_W'(A_FLAG): busRdata[FLAG_W-1:0] = flags;
      default: ;
    endcase
    for (int k = 0; k < NM; k++) begin
      if (busAddr == ADDR_W'(A_MATCH0 + k)) busRdata = matchVal[k];
    end
    for (int c = 0; c < NC; c++) begin
      if (busAddr == ADDR_W'(A_CAP0 + c)) busRdata = capVal[c];
    end
  end

  // R5
  halt_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (haltHit && !wrCtrl) |=> !runBit);

  for (genvar k = 0; k < NM; k++) begin : gChk
    // R6
    match_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      (matchEvt[k] && intMaskM[k]) |=> flags[k]);

    // R8
    pin_invert_chk: assert property (@(posedge clk) disable iff (!rstN)
      (matchEvt[k] && extCode[2*k +: 2] == 2'b11 && !wrExt)
        |=> extOut[k] != $past(extOut[k]));
  end

  // R10
  cap_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capLoad[0] && intMaskC[0]) |=> flags[NM]);

endmodule

// File: rtl/match_capture_timer.sv
module match_capture_timer
  import tmr_pkg::*;
#(
  parameter int W      = 32,
  parameter int NM     = 4,
  parameter int NC     = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [W-1:0]      busWdata,
  output logic [W-1:0]      busRdata,
  input  logic              evtIn,
  input  logic [NC-1:0]     capIn,
  output logic              irq,
  output logic [NM-1:0]     extOut
);

  tmrStrobe_t              strb;
  logic [W-1:0]            prescale, tcount, pcount;
  logic [NM-1:0][W-1:0]    matchVal;
  logic [NC-1:0][W-1:0]    capVal;
  logic [NM-1:0]           matchEq;
  logic [NC-1:0]           capLoad, capRise, capFall;
  logic                    tick;

  tmr_ctrl #(.W(W), .NM(NM), .NC(NC), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tick(tick), .matchEq(matchEq), .tcount(tcount), .pcount(pcount),
    .capRise(capRise), .capFall(capFall), .capVal(capVal),
    .strb(strb), .prescale(prescale), .matchVal(matchVal), .capLoad(capLoad),
    .irq(irq), .extOut(extOut)
  );

  tmr_datapath #(.W(W), .NM(NM), .NC(NC)) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .prescale(prescale),
    .matchVal(matchVal), .capLoad(capLoad), .evtIn(evtIn), .capIn(capIn),
    .tick(tick), .matchEq(matchEq), .tcount(tcount), .pcount(pcount),
    .capRise(capRise), .capFall(capFall), .capVal(capVal)
  );

endmodule

// File: tb/test_match_capture_timer.sv
module test_match_capture_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        evtIn = 1'b0;
  logic [1:0]  capIn = '0;
  logic        irq;
  logic [3:0]  extOut;

  int nTests = 0;
  int nFail  = 0;
  logic probeReq = 1'b0;
  logic finished = 1'b0;

  typedef struct {
    int          src;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t expQ[$];

  match_capture_timer i_match_capture_timer (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evtIn(evtIn),
    .capIn(capIn), .irq(irq), .extOut(extOut)
  );

  always #5 clk = ~clk;

  // all tasks start and end on a falling edge
  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectReg(input logic [3:0] a, input logic [31:0] e, input string r);
    busAddr = a;
    expQ.push_back('{0, e, r});
    probeReq = 1'b1;
    @(negedge clk);
    probeReq = 1'b0;
  endtask

  task automatic expectPin(input int src, input logic [31:0] e, input string r);
    expQ.push_back('{src, e, r});
    probeReq = 1'b1;
    @(negedge clk);
    probeReq = 1'b0;
  endtask

  // monitor: pops the expected item and compares against the port value
  always @(posedge clk) begin
    item_t it;
    logic [31:0] act;
    if (probeReq && expQ.size() > 0) begin
      it  = expQ.pop_front();
      act = (it.src == 0) ? busRdata :
            (it.src == 1) ? {31'b0, irq} : {28'b0, extOut};
      nTests++;
      if (act !== it.exp) begin
        nFail++;
        $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;

    // R1 reset state
    expectReg(4'd0,  32'h0, "R1 control");
    expectReg(4'd2,  32'h0, "R1 count");
    expectReg(4'd10, 32'h0, "R1 pin control");
    expectPin(1, 32'h0, "R1 irq");
    expectPin(2, 32'h0, "R1 extOut");

    // R2 prescale 3, ten enabled edges -> two steps, prescale count 2
    writeReg(4'd1, 32'd3);
    writeReg(4'd0, 32'h1);
    idle(9);
    writeReg(4'd0, 32'h0);
    expectReg(4'd2, 32'd2, "R2 main count");
    expectReg(4'd3, 32'd2, "R2 prescale count");

    // R3 hold zeroes both counts
    writeReg(4'd0, 32'h2);
    idle(2);
    expectReg(4'd2, 32'd0, "R3 main count");
    expectReg(4'd3, 32'd0, "R3 prescale count");

    // R4 clear on match 5 with flag, eight steps -> 2
    writeReg(4'd1, 32'd0);
    writeReg(4'd4, 32'd5);
    writeReg(4'd8, 32'h3);
    writeReg(4'd0, 32'h1);
    idle(7);
    writeReg(4'd0, 32'h0);
    expectReg(4'd2,  32'd2, "R4 wrapped count");
    expectReg(4'd11, 32'h1, "R6 match flag");
    expectPin(1, 32'h1, "R6 irq high");
    writeReg(4'd11, 32'h0);
    expectReg(4'd11, 32'h1, "R7 zero write keeps flag");
    writeReg(4'd11, 32'h1);
    expectReg(4'd11, 32'h0, "R7 flag cleared");
    expectPin(1, 32'h0, "R7 irq low");

    // R5 halt on channel 1 at 3, no flag enabled
    writeReg(4'd0, 32'h2);
    writeReg(4'd8, 32'h20);
    writeReg(4'd5, 32'd3);
    writeReg(4'd0, 32'h1);
    idle(8);
    expectReg(4'd2, 32'd3, "R5 halted count");
    expectReg(4'd0, 32'h0, "R5 run cleared");
    expectPin(1, 32'h0, "R6 no flag when disabled");

    // R8 pin actions: ch0 invert, ch1 high, ch2 low (from 1), ch3 keep (1)
    writeReg(4'd0, 32'h2);
    for (int k = 0; k < 4; k++) writeReg(4'(4 + k), 32'd2);
    writeReg(4'd10, 32'h1BC);
    writeReg(4'd8, 32'h4);
    writeReg(4'd0, 32'h1);
    idle(6);
    expectPin(2, 32'hB, "R8 first match pins");
    expectReg(4'd2, 32'd2, "R5 halt at 2");
    writeReg(4'd0, 32'h1);
    idle(3);
    expectPin(2, 32'hA, "R8 second match pins");
    expectReg(4'd10, 32'h1BA, "R8 pin register");

    // R9/R10 capture with count frozen at 2
    writeReg(4'd10, 32'h0);
    writeReg(4'd8, 32'h0);
    writeReg(4'd9, 32'h15);
    capIn = 2'b11;
    idle(4);
    expectReg(4'd12, 32'd2, "R9 rising snapshot");
    expectReg(4'd13, 32'd0, "R9 rise disabled on ch1");
    expectReg(4'd11, 32'h10, "R10 capture flag");
    expectPin(1, 32'h1, "R10 irq");
    writeReg(4'd0, 32'h2);
    writeReg(4'd0, 32'h1);
    idle(4);
    writeReg(4'd0, 32'h0);
    expectReg(4'd2, 32'd5, "R2 five steps");
    capIn = 2'b00;
    idle(4);
    expectReg(4'd13, 32'd5, "R9 falling snapshot");
    expectReg(4'd12, 32'd2, "R9 fall disabled on ch0");
    expectReg(4'd11, 32'h10, "R10 no flag without enable");
    writeReg(4'd11, 32'h10);
    expectPin(1, 32'h0, "R7 capture flag cleared");

    // R11 external count mode, prescale ignored
    writeReg(4'd1, 32'd5);
    writeReg(4'd0, 32'h2);
    writeReg(4'd0, 32'h5);
    for (int p = 0; p < 3; p++) begin
      evtIn = 1'b1; idle(3);
      evtIn = 1'b0; idle(3);
    end
    idle(3);
    writeReg(4'd0, 32'h0);
    expectReg(4'd2, 32'd3, "R11 event count");
    expectReg(4'd3, 32'd0, "R11 prescale idle");

    idle(2);
    if (expQ.size() != 0) begin
      nFail++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", expQ.size());
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule